// File: doc/BRIEF.md
# TDM Clock Source with External-Clock Fallback

This block supplies the bit clock and frame sync for an eight-channel time-division-multiplexed link. The link carries eight input and eight output channels to a single DSP serial port. Sample data is not handled here. The block only produces the timing that a separate serializer follows: a bit clock, a one-bit frame-sync pulse, the current slot index, and a flag that tells which timing source is in use.

With the mode input low, the block is the timing master. It divides its own clock down to a bit clock and builds frames of 8 slots of 32 bits. It also drives a bit clock and a frame clock to two external stereo ADCs and one external stereo DAC.

With the mode input high, the first external ADC is the timing master. The block samples that ADC's bit clock and frame clock and locks its TDM frame to them. The external clocks may be missing or may stop. If no external bit-clock edge arrives for a fixed number of local clock cycles, the TDM outputs fall back to internally generated timing that is identical to master mode. When a complete external frame clock period is seen again, the block changes back to external timing, but only at a frame start. The source flag and the slot index therefore never show a shortened frame.

Top module: `tdm_clk_source`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is 0.
- R2: Under internal timing, a rising edge of `tdm_fsync_o` occurs every 256*DIV clock cycles (1024 with defaults). The pulse stays high for one bit period: DIV cycles, or 2*half-period cycles under external timing.
- R3: `slot_o` equals bit index / 32 within the 256-bit frame, so it steps 0,1,...,7. `tdm_fsync_o` is high only during bit 255, the last bit of slot 7. Slot 0 begins when the pulse falls.
- R4: When `slave_mode_i` is 0, `conv_bclk_o` follows the internal bit clock, and `conv_lrclk_o` is 1 during slots 0-3 and 0 during slots 4-7. When `slave_mode_i` is 1, both outputs are held at 0.
- R5: When `slave_mode_i` is 0, the external clock inputs are ignored: `src_ext_o` stays 0 and the frame period stays 256*DIV.
- R6: When `slave_mode_i` is 1 and external clocks are running, `src_ext_o` becomes 1 after one full external frame-clock period has been seen. From then on the frame period is 256 external bit periods. An external frame starts with the bit in which `ext_lrclk_i` rises; that signal changes on the falling edge of `ext_bclk_i`.
- R7: If no `ext_bclk_i` edge arrives for TIMEOUT (64) clock cycles, the block leaves external timing. `src_ext_o` returns to 0 and internal timing restarts at slot 0.
- R8: `src_ext_o` changes only in a cycle where `slot_o` is 0 and `tdm_fsync_o` is 0, which is a frame start.
- R9: `tdm_bclk_o` has a period of DIV clock cycles under internal timing. Under external timing its period is the external bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local master clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode_i | input | 1 | 1 = follow external clocks, 0 = generate timing |
| ext_bclk_i | input | 1 | Bit clock from the external ADC (asynchronous) |
| ext_lrclk_i | input | 1 | Frame clock from the external ADC (asynchronous) |
| tdm_bclk_o | output | 1 | TDM bit clock to the DSP port |
| tdm_fsync_o | output | 1 | One-bit frame-sync pulse in the last bit of a frame |
| slot_o | output | 3 | Current TDM slot index |
| src_ext_o | output | 1 | 1 = external timing active |
| conv_bclk_o | output | 1 | Bit clock to the external converters in master mode |
| conv_lrclk_o | output | 1 | Frame clock to the external converters in master mode |

## Verification
All outputs are registered together, so an internal bit boundary shows on the pins one cycle after the divider wraps. An external clock edge shows about four cycles after the pin changes, because of the synchronizer, the edge register and the output register.

Because of these latencies, the bench does not compare individual edges. It measures intervals between rising edges, sampled on the falling clock edge, so a fixed latency cancels out. Each stimulus vector is also allowed 8000 cycles to settle before anything is measured, which covers the lock time plus the wait for a frame start.

The loss of external clocks is checked at two points around the expected fallback at about 68 cycles. At 30 cycles after the stop the flag must still be 1. At 150 cycles it must be 0 and `slot_o` must be 0. Slot values are read in the middle of each slot, so the exact boundary cycle does not matter.

// File: rtl/tdmc_pkg.sv
package tdmc_pkg;
  typedef enum logic [1:0] {
    SRC_INT  = 2'd0,
    SRC_WAIT = 2'd1,
    SRC_EXT  = 2'd2
  } src_state_e;
endpackage

// File: rtl/tdmc_sync.sv
module tdmc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tdmc_div.sv
module tdmc_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic m_adv,
  output logic m_bclk
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [DW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst)                       dcnt <= '0;
    else if (restart)              dcnt <= DW'(1);
    else if (dcnt == DW'(DIV - 1)) dcnt <= '0;
    else                           dcnt <= dcnt + 1'b1;
  end

  assign m_adv  = (dcnt == '0);
  assign m_bclk = (dcnt >= DW'(DIV / 2));
endmodule

// File: rtl/tdmc_ext_mon.sv
module tdmc_ext_mon #(
  parameter int FRAME_BITS  = 256,
  parameter int TIMEOUT     = 64,
  parameter int SYNC_STAGES = 2,
  localparam int BW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_bclk_i,
  input  logic          ext_lrclk_i,
  output logic          e_adv,
  output logic [BW-1:0] e_bit,
  output logic          e_bclk,
  output logic          alive,
  output logic          locked
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [1:0]    sy;
  logic          bclk_d, lr_mid, lr_mid_prev;
  logic          rise, fall, lr_edge;
  logic [TW-1:0] tcnt;
  logic [1:0]    frames;

  tdmc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ext_lrclk_i, ext_bclk_i}),
    .q   (sy)
  );

  assign rise    = sy[0] & ~bclk_d;
  assign fall    = ~sy[0] & bclk_d;
  assign lr_edge = lr_mid & ~lr_mid_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d      <= 1'b0;
      lr_mid      <= 1'b0;
      lr_mid_prev <= 1'b0;
      tcnt        <= TW'(TIMEOUT);
      frames      <= '0;
      e_bit       <= '0;
      e_adv       <= 1'b0;
    end else begin
      bclk_d <= sy[0];
      e_adv  <= fall;
      if (rise) begin
        lr_mid_prev <= lr_mid;
        lr_mid      <= sy[1];
      end
      if (rise | fall)               tcnt <= '0;
      else if (tcnt != TW'(TIMEOUT)) tcnt <= tcnt + 1'b1;
      if (fall) e_bit <= lr_edge ? BW'(1) : e_bit + 1'b1;
      if (!alive)                                  frames <= '0;
      else if (fall && lr_edge && frames != 2'd2)  frames <= frames + 1'b1;
    end
  end

  assign e_bclk = bclk_d;
  assign alive  = (tcnt != TW'(TIMEOUT));
  assign locked = alive && (frames == 2'd2);
endmodule

// File: rtl/tdmc_src_ctrl.sv
module tdmc_src_ctrl
  import tdmc_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int SLOT_BITS = 32,
  localparam int FRAME_BITS = SLOTS * SLOT_BITS,
  localparam int BW = $clog2(FRAME_BITS),
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slave_mode,
  input  logic          m_adv,
  input  logic          m_bclk,
  input  logic          e_adv,
  input  logic [BW-1:0] e_bit,
  input  logic          e_bclk,
  input  logic          e_alive,
  input  logic          e_locked,
  output logic          restart,
  output logic          bclk_o,
  output logic          fsync_o,
  output logic [SW-1:0] slot_o,
  output logic          src_ext_o,
  output logic          conv_bclk_o,
  output logic          conv_lrclk_o
);
  localparam int LSB = $clog2(SLOT_BITS);
  localparam logic [BW-1:0] LAST = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] HALF = BW'(FRAME_BITS / 2);

  src_state_e    state, state_n;
  logic [BW-1:0] bitcnt, bit_n;
  logic          ext_ready;

  assign ext_ready = slave_mode && e_locked;

  always_comb begin
    state_n = state;
    bit_n   = bitcnt;
    restart = 1'b0;
    unique case (state)
      SRC_INT: begin
        if (m_adv) begin
          if (bitcnt == LAST) begin
            if (ext_ready) state_n = SRC_WAIT;
            else           bit_n   = '0;
          end else begin
            bit_n = bitcnt + 1'b1;
          end
        end
      end
      SRC_WAIT: begin
        if (!ext_ready) begin
          state_n = SRC_INT;
          restart = 1'b1;
          bit_n   = '0;
        end else if (e_adv && e_bit == '0) begin
          state_n = SRC_EXT;
          bit_n   = '0;
        end
      end
      SRC_EXT: begin
        if (!e_alive || (e_adv && e_bit == '0 && !slave_mode)) begin
          state_n = SRC_INT;
          restart = 1'b1;
          bit_n   = '0;
        end else if (e_adv) begin
          bit_n = e_bit;
        end
      end
      default: begin
        state_n = SRC_INT;
        restart = 1'b1;
        bit_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SRC_INT;
      bitcnt       <= LAST;
      bclk_o       <= 1'b0;
      fsync_o      <= 1'b0;
      slot_o       <= '0;
      src_ext_o    <= 1'b0;
      conv_bclk_o  <= 1'b0;
      conv_lrclk_o <= 1'b0;
    end else begin
      state     <= state_n;
      bitcnt    <= bit_n;
      slot_o    <= bit_n[BW-1:LSB];
      fsync_o   <= (state_n != SRC_WAIT) && (bit_n == LAST);
      src_ext_o <= (state_n == SRC_EXT);
      if (state_n == SRC_EXT)                 bclk_o <= e_bclk;
      else if (state_n == SRC_INT && !restart) bclk_o <= m_bclk;
      else                                    bclk_o <= 1'b0;
      conv_bclk_o  <= !slave_mode && state_n == SRC_INT && !restart && m_bclk;
      conv_lrclk_o <= !slave_mode && state_n == SRC_INT && (bit_n < HALF);
    end
  end
endmodule

// File: rtl/tdm_clk_source.sv
module tdm_clk_source #(
  parameter int DIV         = 4,
  parameter int SLOTS       = 8,
  parameter int SLOT_BITS   = 32,
  parameter int TIMEOUT     = 64,
  parameter int SYNC_STAGES = 2,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slave_mode_i,
  input  logic          ext_bclk_i,
  input  logic          ext_lrclk_i,
  output logic          tdm_bclk_o,
  output logic          tdm_fsync_o,
  output logic [SW-1:0] slot_o,
  output logic          src_ext_o,
  output logic          conv_bclk_o,
  output logic          conv_lrclk_o
);
  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int BW = $clog2(FRAME_BITS);

  logic          restart, m_adv, m_bclk;
  logic          e_adv, e_bclk, e_alive, e_locked;
  logic [BW-1:0] e_bit;

  tdmc_div #(.DIV(DIV)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .m_adv   (m_adv),
    .m_bclk  (m_bclk)
  );

  tdmc_ext_mon #(
    .FRAME_BITS  (FRAME_BITS),
    .TIMEOUT     (TIMEOUT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_mon (
    .clk         (clk),
    .rst         (rst),
    .ext_bclk_i  (ext_bclk_i),
    .ext_lrclk_i (ext_lrclk_i),
    .e_adv       (e_adv),
    .e_bit       (e_bit),
    .e_bclk      (e_bclk),
    .alive       (e_alive),
    .locked      (e_locked)
  );

  tdmc_src_ctrl #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .slave_mode   (slave_mode_i),
    .m_adv        (m_adv),
    .m_bclk       (m_bclk),
    .e_adv        (e_adv),
    .e_bit        (e_bit),
    .e_bclk       (e_bclk),
    .e_alive      (e_alive),
    .e_locked     (e_locked),
    .restart      (restart),
    .bclk_o       (tdm_bclk_o),
    .fsync_o      (tdm_fsync_o),
    .slot_o       (slot_o),
    .src_ext_o    (src_ext_o),
    .conv_bclk_o  (conv_bclk_o),
    .conv_lrclk_o (conv_lrclk_o)
  );
endmodule

// File: rtl/tdm_clk_source_chk.sv
module tdm_clk_source_chk #(
  parameter int SLOTS   = 8,
  parameter int TIMEOUT = 64,
  localparam int SW = $clog2(SLOTS)
) (
  input logic          clk,
  input logic          rst,
  input logic          slave_mode_i,
  input logic          ext_bclk_i,
  input logic          tdm_fsync_o,
  input logic [SW-1:0] slot_o,
  input logic          src_ext_o,
  input logic          conv_bclk_o,
  input logic          conv_lrclk_o
);
  localparam int LIMIT = TIMEOUT + 8;
  localparam int QW    = $clog2(LIMIT + 1);
  localparam logic [SW-1:0] ONE = SW'(1);

  logic          bclk_q;
  logic [QW-1:0] quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b0;
      quiet  <= '0;
    end else begin
      bclk_q <= ext_bclk_i;
      if (ext_bclk_i != bclk_q) quiet <= '0;
      else if (quiet != QW'(LIMIT)) quiet <= quiet + 1'b1;
    end
  end

  a_r8_src_at_boundary: assert property (@(posedge clk) disable iff (rst)
    (src_ext_o != $past(src_ext_o)) |-> (slot_o == '0 && !tdm_fsync_o));

  a_r3_fsync_in_last_slot: assert property (@(posedge clk) disable iff (rst)
    tdm_fsync_o |-> (slot_o == SW'(SLOTS - 1)));

  a_r3_slot_steps: assert property (@(posedge clk) disable iff (rst)
    (slot_o != $past(slot_o) && !src_ext_o && !$past(src_ext_o))
      |-> (slot_o == $past(slot_o) + ONE));

  a_r4_conv_quiet_slave: assert property (@(posedge clk) disable iff (rst)
    $past(slave_mode_i) |-> (!conv_bclk_o && !conv_lrclk_o));

  a_r5_master_stays_internal: assert property (@(posedge clk) disable iff (rst)
    (!slave_mode_i && !src_ext_o) |=> !src_ext_o);

  a_r7_timeout_fallback: assert property (@(posedge clk) disable iff (rst)
    (quiet == QW'(LIMIT)) |-> !src_ext_o);
endmodule

bind tdm_clk_source tdm_clk_source_chk #(.SLOTS(SLOTS), .TIMEOUT(TIMEOUT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .slave_mode_i (slave_mode_i),
  .ext_bclk_i   (ext_bclk_i),
  .tdm_fsync_o  (tdm_fsync_o),
  .slot_o       (slot_o),
  .src_ext_o    (src_ext_o),
  .conv_bclk_o  (conv_bclk_o),
  .conv_lrclk_o (conv_lrclk_o)
);

// File: tb/tdm_clk_source_tb_top.sv
`timescale 1ns/1ps
module tdm_clk_source_tb_top;
  localparam int DIV    = 4;
  localparam int NBITS  = 8 * 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slave_mode = 1'b0;
  logic ext_bclk = 1'b0;
  logic ext_lrclk = 1'b0;
  logic tdm_bclk, tdm_fsync, src_ext, conv_bclk, conv_lrclk;
  logic [2:0] slot;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit        ext_run = 1'b0;
  int        ext_half = 3;
  int        hc = 0;
  logic [7:0] eb = 8'd255;

  always #2.5 clk = ~clk;

  tdm_clk_source dut_i (
    .clk          (clk),
    .rst          (rst),
    .slave_mode_i (slave_mode),
    .ext_bclk_i   (ext_bclk),
    .ext_lrclk_i  (ext_lrclk),
    .tdm_bclk_o   (tdm_bclk),
    .tdm_fsync_o  (tdm_fsync),
    .slot_o       (slot),
    .src_ext_o    (src_ext),
    .conv_bclk_o  (conv_bclk),
    .conv_lrclk_o (conv_lrclk)
  );

  typedef struct packed {
    logic       slave;
    logic       run;
    logic [7:0] half;
    logic       exp_src;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 8'd3, 1'b0},
    '{1'b0, 1'b1, 8'd3, 1'b0},
    '{1'b1, 1'b1, 8'd3, 1'b1},
    '{1'b1, 1'b1, 8'd4, 1'b1},
    '{1'b1, 1'b0, 8'd4, 1'b0},
    '{1'b0, 1'b0, 8'd3, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // External converter model: LRCLK changes with BCLK falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (!ext_run) begin
        ext_bclk = 1'b0; ext_lrclk = 1'b0; hc = 0; eb = 8'd255;
      end else begin
        hc++;
        if (hc >= ext_half) begin
          hc = 0;
          ext_bclk = ~ext_bclk;
          if (!ext_bclk) begin
            eb = eb + 8'd1;
            ext_lrclk = (eb < 8'd128);
          end
        end
      end
    end
  end

  // R8: every change of the source flag lands on a frame start.
  initial begin
    logic sp;
    sp = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst && src_ext !== sp)
        check(slot == 3'd0 && !tdm_fsync, "R8", "slot at src change",
              int'(slot), 0);
      sp = src_ext;
    end
  end

  task automatic next_rise(input bit sel_fsync, output int cyc);
    logic p;
    p = sel_fsync ? tdm_fsync : tdm_bclk;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if ((sel_fsync ? tdm_fsync : tdm_bclk) && !p) break;
      p = sel_fsync ? tdm_fsync : tdm_bclk;
      if (cyc > 20000) break;
    end
  endtask

  task automatic high_width(output int w);
    w = 0;
    while (tdm_fsync && w < 20000) begin
      @(negedge clk);
      w++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int fper, fwid, bper, dummy;
    bit conv_hi;
    string tg;

    // R1: reset state
    repeat (6) @(negedge clk);
    check({tdm_bclk, tdm_fsync, slot, src_ext, conv_bclk, conv_lrclk} == 8'd0,
          "R1", "outputs in reset", int'({tdm_bclk, tdm_fsync, slot, src_ext}), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check({tdm_fsync, slot, src_ext} == 5'd0, "R1", "outputs after reset",
          int'({tdm_fsync, slot, src_ext}), 0);

    // Vector table walk: R2, R4, R5, R6, R7, R9
    for (int v = 0; v < 6; v++) begin
      slave_mode = VECS[v].slave;
      ext_run    = VECS[v].run;
      ext_half   = int'(VECS[v].half);
      repeat (8000) @(negedge clk);
      tg = VECS[v].exp_src ? "R6" : (VECS[v].slave ? "R7" : "R5");
      check(src_ext == VECS[v].exp_src, tg, "src flag", int'(src_ext),
            int'(VECS[v].exp_src));
      next_rise(1'b1, dummy);
      next_rise(1'b1, fper);
      high_width(fwid);
      check(fper == (VECS[v].exp_src ? NBITS * 2 * ext_half : NBITS * DIV),
            tg, "frame period", fper,
            VECS[v].exp_src ? NBITS * 2 * ext_half : NBITS * DIV);
      check(fwid == (VECS[v].exp_src ? 2 * ext_half : DIV), "R2", "fsync width",
            fwid, VECS[v].exp_src ? 2 * ext_half : DIV);
      next_rise(1'b0, dummy);
      next_rise(1'b0, bper);
      check(bper == (VECS[v].exp_src ? 2 * ext_half : DIV), "R9", "bclk period",
            bper, VECS[v].exp_src ? 2 * ext_half : DIV);
      if (VECS[v].slave) begin
        conv_hi = 1'b0;
        for (int k = 0; k < 600; k++) begin
          @(negedge clk);
          conv_hi = conv_hi | conv_bclk | conv_lrclk;
        end
        check(!conv_hi, "R4", "converter clocks in slave mode", int'(conv_hi), 0);
      end
    end

    // R3 / R4: slot sequence and converter frame clock in master mode
    next_rise(1'b1, dummy);
    high_width(fwid);
    check(slot == 3'd0, "R3", "slot after fsync", int'(slot), 0);
    repeat (64) @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      check(slot == 3'(s), "R3", "slot mid value", int'(slot), s);
      check(conv_lrclk == (s < 4), "R4", "converter frame clock",
            int'(conv_lrclk), int'(s < 4));
      check(!tdm_fsync, "R3", "no fsync mid slot", int'(tdm_fsync), 0);
      if (s < 7) repeat (128) @(negedge clk);
    end
    conv_hi = 1'b1;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (conv_bclk !== tdm_bclk) conv_hi = 1'b0;
    end
    check(conv_hi, "R4", "converter bclk follows tdm bclk", int'(conv_hi), 1);

    // R7: timeout window after external clocks stop
    slave_mode = 1'b1; ext_half = 3; ext_run = 1'b1;
    repeat (8000) @(negedge clk);
    check(src_ext == 1'b1, "R6", "locked before stop", int'(src_ext), 1);
    ext_run = 1'b0;
    repeat (30) @(negedge clk);
    check(src_ext == 1'b1, "R7", "still external before timeout", int'(src_ext), 1);
    repeat (120) @(negedge clk);
    check(src_ext == 1'b0, "R7", "fallback after timeout", int'(src_ext), 0);
    check(slot == 3'd0, "R7", "fresh frame at slot 0", int'(slot), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule